// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home node for a set of memory blocks in a shared-memory system that keeps caches coherent without broadcasting. For every block it keeps a directory entry: a state and a presence bitmap with one bit per processor. A processor that misses on a read, misses on a write, or wants to write a block it holds clean in the shared state sends a request. The controller reads the entry, sends invalidate or fetch messages only to the processors the bitmap marks, collects their acknowledgements, updates the entry and the home memory copy, and then grants the block to the requester with its data.

Only one transaction is in flight at a time. The request port stays not-ready from the cycle a request is taken until the cycle after its reply. A request to a block that has a transaction pending therefore waits, which puts all writes to one block into a single order. The network that carries messages and the caches themselves sit outside the block. Messages leave on one valid line per processor, with a shared 2-bit type and the block address. Acknowledgements return on one valid line per processor, with a data word per processor.

Top module: `dir_top`

## Requirements
- R1: After reset every entry is Uncached with an empty bitmap, every home memory word is zero, `reqReady` is 1, and `msgValid` and `rspValid` are 0.
- R2: A request is taken when `reqValid` and `reqReady` are both 1. `reqType` 0 is a read miss. A read miss to an Uncached or Shared block sends no message. It replies with the home memory word, leaves the block Shared, and adds the requester's bit to the bitmap.
- R3: A read miss to an Exclusive block owned by another processor sends one fetch message (type 2) to the owner only. It writes the owner's acknowledgement data into home memory and replies with that data. The block ends Shared with both the owner's and the requester's bits set.
- R4: `reqType` 1 is a write miss and `reqType` 2 is a write to a held Shared block; code 3 is handled as a write miss. A write to a Shared block sends an invalidate (type 1) to every marked processor except the requester. The reply waits until every one of those processors has acknowledged. The block then ends Exclusive with only the requester's bit set, and invalidate acknowledgement data does not change home memory.
- R5: A write to an Exclusive block owned by another processor sends a fetch-and-invalidate (type 3) to that owner only. It writes the returned data to home memory, replies with it, and makes the requester the only owner.
- R6: A write to an Uncached block, or to an Exclusive block the requester already owns, sends no message. It replies at once with the home memory word and leaves the block Exclusive with only the requester's bit set.
- R7: A message is never sent to a processor whose bit is clear in the entry's bitmap, is never sent to the requester, and each `msgValid` bit is high for a single cycle per transaction.
- R8: `reqReady` goes low in the cycle after a request is taken and stays low through the reply cycle, so a second request, even to the same block, waits until the first finishes.
- R9: An acknowledgement from a processor that is not awaited in the current transaction is ignored: its data does not reach home memory or the reply.
- R10: A reply holds `rspValid` high for exactly one cycle. It carries the requester in `rspProc`, the block in `rspAddr`, the data in `rspData`, and `rspType` 0 for a shared grant (read) or 1 for an exclusive grant (write).
- R11: An Exclusive entry has exactly one bitmap bit set, a Shared entry has at least one, and an Uncached entry has none.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 write to held Shared block, 3 as write miss |
| reqProc | input | PROC_W (2) | Requesting processor |
| reqAddr | input | ADDR_W (4) | Block index |
| msgValid | output | NUM_PROCS (4) | One message strobe per processor |
| msgType | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 0 when idle |
| msgAddr | output | ADDR_W (4) | Block the message refers to |
| ackValid | input | NUM_PROCS (4) | One acknowledgement strobe per processor |
| ackData | input | NUM_PROCS*DATA_W (128) | Returned block data, processor i in bits i*DATA_W upward |
| rspValid | output | 1 | Reply strobe |
| rspProc | output | PROC_W (2) | Processor the reply goes to |
| rspAddr | output | ADDR_W (4) | Block granted |
| rspType | output | 1 | 0 shared grant, 1 exclusive grant |
| rspData | output | DATA_W (32) | Block data |

## Verification
The bench targets the transitions where a wrong directory gets through its own bookkeeping but corrupts data or sends traffic to the wrong place. These cases are a read of a block that another processor owns dirty, a write that must invalidate several sharers but not the writer, and the hand-off of ownership from one writer to the next. A controller that skipped the fetch or lost the write-back would return stale zeros. One that broadcast or forgot to mask the requester would send a message to an unexpected processor. One that replied before the last invalidation acknowledgement would grant while a sharer still held its copy. The bench also sends stray acknowledgements, with a poison value, from processors that are not awaited, and an invalidate acknowledgement that carries zero data. A design that takes data from any acknowledgement would show these values in a later reply. It also covers writes by the current owner and the last block index.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    REQ_READ    = 2'd0,
    REQ_WRITE   = 2'd1,
    REQ_UPGRADE = 2'd2,
    REQ_ALTW    = 2'd3
  } req_kind_t;

  typedef enum logic [1:0] {
    DS_UNCACHED = 2'd0,
    DS_SHARED   = 2'd1,
    DS_EXCL     = 2'd2
  } dir_state_t;

  typedef enum logic [1:0] {
    MSG_NONE      = 2'd0,
    MSG_INV       = 2'd1,
    MSG_FETCH     = 2'd2,
    MSG_FETCH_INV = 2'd3
  } msg_kind_t;

  typedef enum logic {
    RSP_SHARED = 1'b0,
    RSP_EXCL   = 1'b1
  } rsp_kind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      latchReq;
    logic      loadPend;
    msg_kind_t kind;
    logic      sendMsg;
    logic      ackEn;
    logic      commit;
  } ctrl_strobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 32,
  localparam int PROC_W    = $clog2(NUM_PROCS),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrl_strobe_t                strb,
  input  logic [1:0]                  reqType,
  input  logic [PROC_W-1:0]           reqProc,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [NUM_PROCS-1:0]        ackValid,
  input  logic [NUM_PROCS*DATA_W-1:0] ackData,
  output dir_state_t                  curState,
  output logic [NUM_PROCS-1:0]        curBits,
  output logic [NUM_PROCS-1:0]        reqOneHot,
  output logic                        reqIsRead,
  output logic                        otherHolders,
  output logic                        pendEmpty,
  output logic [NUM_PROCS-1:0]        msgValid,
  output logic [1:0]                  msgType,
  output logic [ADDR_W-1:0]           msgAddr,
  output logic [PROC_W-1:0]           rspProc,
  output logic [ADDR_W-1:0]           rspAddr,
  output logic                        rspType,
  output logic [DATA_W-1:0]           rspData
);

  dir_state_t           stateArr [NUM_BLOCKS];
  logic [NUM_PROCS-1:0] bitsArr  [NUM_BLOCKS];
  logic [DATA_W-1:0]    memArr   [NUM_BLOCKS];

  logic [1:0]           typeReg;
  logic [PROC_W-1:0]    procReg;
  logic [ADDR_W-1:0]    addrReg;
  logic [NUM_PROCS-1:0] pendMask;
  msg_kind_t            kindReg;
  logic                 kindCarriesData;

  assign curState        = stateArr[addrReg];
  assign curBits         = bitsArr[addrReg];
  assign reqOneHot       = {{(NUM_PROCS-1){1'b0}}, 1'b1} << procReg;
  assign reqIsRead       = (typeReg == REQ_READ);
  assign otherHolders    = |(curBits & ~reqOneHot);
  assign pendEmpty       = (pendMask == '0);
  assign kindCarriesData = (kindReg == MSG_FETCH) || (kindReg == MSG_FETCH_INV);

  assign msgValid = strb.sendMsg ? pendMask : '0;
  assign msgType  = strb.sendMsg ? kindReg : MSG_NONE;
  assign msgAddr  = addrReg;

  assign rspProc = procReg;
  assign rspAddr = addrReg;
  assign rspType = reqIsRead ? RSP_SHARED : RSP_EXCL;
  assign rspData = memArr[addrReg];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      typeReg  <= '0;
      procReg  <= '0;
      addrReg  <= '0;
      pendMask <= '0;
      kindReg  <= MSG_NONE;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        stateArr[b] <= DS_UNCACHED;
        bitsArr[b]  <= '0;
        memArr[b]   <= '0;
      end
    end else begin
      if (strb.latchReq) begin
        typeReg <= reqType;
        procReg <= reqProc;
        addrReg <= reqAddr;
      end
      if (strb.loadPend) begin
        pendMask <= curBits & ~reqOneHot;
        kindReg  <= strb.kind;
      end else if (strb.ackEn) begin
        pendMask <= pendMask & ~ackValid;
        for (int p = 0; p < NUM_PROCS; p++) begin
          if (ackValid[p] && pendMask[p] && kindCarriesData)
            memArr[addrReg] <= ackData[p*DATA_W +: DATA_W];
        end
      end
      if (strb.commit) begin
        if (reqIsRead) begin
          stateArr[addrReg] <= DS_SHARED;
          bitsArr[addrReg]  <= curBits | reqOneHot;
        end else begin
          stateArr[addrReg] <= DS_EXCL;
          bitsArr[addrReg]  <= reqOneHot;
        end
      end
    end
  end

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  dir_state_t   curState,
  input  logic         reqIsRead,
  input  logic         otherHolders,
  input  logic         pendEmpty,
  output logic         reqReady,
  output logic         rspValid,
  output ctrl_strobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOKUP, ST_SEND, ST_WAIT, ST_REPLY
  } ctrl_state_t;

  ctrl_state_t state, nextState;
  msg_kind_t   lookupKind;

  // which message a request needs, given the entry state
  always_comb begin
    lookupKind = MSG_NONE;
    if (reqIsRead) begin
      if (curState == DS_EXCL) lookupKind = MSG_FETCH;
    end else begin
      unique case (curState)
        DS_SHARED: lookupKind = MSG_INV;
        DS_EXCL:   lookupKind = MSG_FETCH_INV;
        default:   lookupKind = MSG_NONE;
      endcase
    end
  end

  always_comb begin
    strb      = '0;
    reqReady  = 1'b0;
    rspValid  = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          nextState     = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if ((lookupKind != MSG_NONE) && otherHolders) begin
          strb.loadPend = 1'b1;
          strb.kind     = lookupKind;
          nextState     = ST_SEND;
        end else begin
          nextState = ST_REPLY;
        end
      end
      ST_SEND: begin
        strb.sendMsg = 1'b1;
        strb.ackEn   = 1'b1;
        nextState    = ST_WAIT;
      end
      ST_WAIT: begin
        strb.ackEn = 1'b1;
        if (pendEmpty) nextState = ST_REPLY;
      end
      ST_REPLY: begin
        rspValid    = 1'b1;
        strb.commit = 1'b1;
        nextState   = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/dir_top.sv
module dir_top
  import dir_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_BLOCKS = 16,
  parameter int DATA_W     = 32,
  localparam int PROC_W    = $clog2(NUM_PROCS),
  localparam int ADDR_W    = $clog2(NUM_BLOCKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [1:0]                  reqType,
  input  logic [PROC_W-1:0]           reqProc,
  input  logic [ADDR_W-1:0]           reqAddr,
  output logic [NUM_PROCS-1:0]        msgValid,
  output logic [1:0]                  msgType,
  output logic [ADDR_W-1:0]           msgAddr,
  input  logic [NUM_PROCS-1:0]        ackValid,
  input  logic [NUM_PROCS*DATA_W-1:0] ackData,
  output logic                        rspValid,
  output logic [PROC_W-1:0]           rspProc,
  output logic [ADDR_W-1:0]           rspAddr,
  output logic                        rspType,
  output logic [DATA_W-1:0]           rspData
);

  ctrl_strobe_t         strb;
  dir_state_t           entState;
  logic [NUM_PROCS-1:0] entBits;
  logic [NUM_PROCS-1:0] reqOneHot;
  logic                 reqIsRead;
  logic                 otherHolders;
  logic                 pendEmpty;

  dir_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .curState     (entState),
    .reqIsRead    (reqIsRead),
    .otherHolders (otherHolders),
    .pendEmpty    (pendEmpty),
    .reqReady     (reqReady),
    .rspValid     (rspValid),
    .strb         (strb)
  );

  dir_datapath #(
    .NUM_PROCS  (NUM_PROCS),
    .NUM_BLOCKS (NUM_BLOCKS),
    .DATA_W     (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqType      (reqType),
    .reqProc      (reqProc),
    .reqAddr      (reqAddr),
    .ackValid     (ackValid),
    .ackData      (ackData),
    .curState     (entState),
    .curBits      (entBits),
    .reqOneHot    (reqOneHot),
    .reqIsRead    (reqIsRead),
    .otherHolders (otherHolders),
    .pendEmpty    (pendEmpty),
    .msgValid     (msgValid),
    .msgType      (msgType),
    .msgAddr      (msgAddr),
    .rspProc      (rspProc),
    .rspAddr      (rspAddr),
    .rspType      (rspType),
    .rspData      (rspData)
  );

endmodule

// File: rtl/dir_checker.sv
module dir_checker
  import dir_pkg::*;
#(
  parameter int NUM_PROCS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [NUM_PROCS-1:0] msgValid,
  input logic                 rspValid,
  input dir_state_t           entState,
  input logic [NUM_PROCS-1:0] entBits,
  input logic [NUM_PROCS-1:0] reqOneHot
);

  assert_msg_in_bitmap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid != '0) |-> ((msgValid & ~entBits) == '0));

  assert_msg_skips_requester_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid != '0) |-> ((msgValid & reqOneHot) == '0));

  assert_msg_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid != '0) |=> (msgValid == '0));

  assert_excl_one_owner_R11: assert property (@(posedge clk) disable iff (!rstN)
    (entState == DS_EXCL) |-> ($countones(entBits) == 1));

  assert_shared_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (entState == DS_SHARED) |-> ($countones(entBits) >= 1));

  assert_uncached_empty_R11: assert property (@(posedge clk) disable iff (!rstN)
    (entState == DS_UNCACHED) |-> (entBits == '0));

  assert_one_in_flight_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  assert_no_reply_when_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !reqReady);

  assert_reply_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind dir_top dir_checker #(.NUM_PROCS(NUM_PROCS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .msgValid  (msgValid),
  .rspValid  (rspValid),
  .entState  (entState),
  .entBits   (entBits),
  .reqOneHot (reqOneHot)
);

// File: tb/sim_dir_top.sv
module sim_dir_top;

  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 32;

  typedef struct {
    logic [NP-1:0] mask;
    logic [1:0]    kind;
    logic [3:0]    addr;
    logic [DW-1:0] retData;
  } msg_exp_t;

  typedef struct {
    logic [1:0]    proc;
    logic [3:0]    addr;
    logic          kind;
    logic [DW-1:0] data;
    bit            hadMsg;
  } rsp_exp_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             reqValid = 1'b0;
  logic             reqReady;
  logic [1:0]       reqType = '0;
  logic [1:0]       reqProc = '0;
  logic [3:0]       reqAddr = '0;
  logic [NP-1:0]    msgValid;
  logic [1:0]       msgType;
  logic [3:0]       msgAddr;
  logic [NP-1:0]    ackValid = '0;
  logic [NP*DW-1:0] ackData = '0;
  logic             rspValid;
  logic [1:0]       rspProc;
  logic [3:0]       rspAddr;
  logic             rspType;
  logic [DW-1:0]    rspData;

  always #2 clk = ~clk;

  dir_top u0 (.*);

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int rspSeen = 0;
  int cycles = 0;
  int outstanding = 0;
  bit strayOn = 0;

  msg_exp_t msgQ[$];
  rsp_exp_t rspQ[$];

  // reference directory
  logic [1:0]    mState [NB];
  logic [NP-1:0] mBits  [NB];
  logic [DW-1:0] mMem   [NB];
  logic [DW-1:0] mOwner [NB];

  int            ackCnt [NP];
  logic [DW-1:0] ackDat [NP];
  logic [NP-1:0] realAcks = '0;
  int            strayCnt = 0;
  int            strayProc = 0;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
      finishRun();
    end
  end

  // responder and scoreboard monitor
  always @(negedge clk) begin
    ackValid = '0;
    outstanding -= $countones(realAcks);
    realAcks = '0;
    for (int i = 0; i < NP; i++) begin
      if (ackCnt[i] != 0) begin
        ackCnt[i]--;
        if (ackCnt[i] == 0) begin
          ackValid[i] = 1'b1;
          ackData[i*DW +: DW] = ackDat[i];
          realAcks[i] = 1'b1;
        end
      end
    end
    if (strayCnt != 0) begin
      strayCnt--;
      if (strayCnt == 0) begin
        ackValid[strayProc] = 1'b1;
        ackData[strayProc*DW +: DW] = 32'hDEAD_BEEF;
      end
    end
    if (rstN && msgValid != '0) begin
      if (msgQ.size() == 0) begin
        check(1'b0, "R7 unexpected message", {124'd0, msgValid}, 128'd0);
      end else begin
        msg_exp_t e;
        e = msgQ.pop_front();
        check(msgValid == e.mask, "R7 message targets", {124'd0, msgValid}, {124'd0, e.mask});
        check(msgType == e.kind, "R3/R4/R5 message type", {126'd0, msgType}, {126'd0, e.kind});
        check(msgAddr == e.addr, "R7 message address", {124'd0, msgAddr}, {124'd0, e.addr});
        if (e.kind != 2'd1)
          check($countones(msgValid) == 1, "R11 single owner fetched", {124'd0, msgValid}, {124'd0, e.mask});
        for (int i = 0; i < NP; i++) begin
          if (msgValid[i]) begin
            ackCnt[i] = 3 + i;
            ackDat[i] = e.retData;
            outstanding++;
          end
        end
        if (strayOn && e.kind != 2'd1) begin
          for (int i = 0; i < NP; i++)
            if (msgValid[i]) strayProc = (i + 1) % NP;
          strayCnt = 2;
        end
      end
    end
    if (rstN && rspValid) begin
      if (rspQ.size() == 0) begin
        check(1'b0, "R10 unexpected reply", 128'd1, 128'd0);
      end else begin
        rsp_exp_t r;
        r = rspQ.pop_front();
        check(rspProc == r.proc, "R10 reply processor", {126'd0, rspProc}, {126'd0, r.proc});
        check(rspAddr == r.addr, "R10 reply address", {124'd0, rspAddr}, {124'd0, r.addr});
        check(rspType == r.kind, "R10 reply type", {127'd0, rspType}, {127'd0, r.kind});
        check(rspData == r.data, "R2/R3/R5/R9 reply data", {96'd0, rspData}, {96'd0, r.data});
        if (r.hadMsg)
          check(outstanding == 0, "R4 reply before all acks", outstanding, 128'd0);
      end
      rspSeen++;
    end
  end

  // driver: computes the expected outcome from the requirements, then issues the request
  task automatic doReq(input int p, input int t, input int a, input bit stray);
    logic [NP-1:0] rb, tgt;
    bit            isRead;
    msg_exp_t      m;
    rsp_exp_t      r;
    rb = NP'(1) << p;
    tgt = mBits[a] & ~rb;
    isRead = (t == 0);
    r.hadMsg = 0;
    if (isRead) begin
      if (mState[a] == 2'd2 && tgt != '0) begin         // R3
        m = '{tgt, 2'd2, 4'(a), mOwner[a]};
        msgQ.push_back(m);
        mMem[a] = mOwner[a];
        r.hadMsg = 1;
      end
      mState[a] = 2'd1;                                  // R2
      mBits[a]  = mBits[a] | rb;
    end else begin
      if (mState[a] == 2'd1 && tgt != '0) begin          // R4
        m = '{tgt, 2'd1, 4'(a), 32'd0};
        msgQ.push_back(m);
        r.hadMsg = 1;
      end else if (mState[a] == 2'd2 && tgt != '0) begin // R5
        m = '{tgt, 2'd3, 4'(a), mOwner[a]};
        msgQ.push_back(m);
        mMem[a] = mOwner[a];
        r.hadMsg = 1;
      end
      mState[a] = 2'd2;                                  // R6
      mBits[a]  = rb;
      mOwner[a] = 32'hC000_0000 | (32'(issued & 255) << 8) | (32'(p) << 4) | 32'(a);
    end
    r.proc = 2'(p);
    r.addr = 4'(a);
    r.kind = isRead ? 1'b0 : 1'b1;
    r.data = mMem[a];
    rspQ.push_back(r);
    strayOn = stray;
    issued++;

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqType  = 2'(t);
    reqProc  = 2'(p);
    reqAddr  = 4'(a);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R8 not ready while busy", {127'd0, reqReady}, 128'd0);
    while (rspSeen != issued) @(negedge clk);
  endtask

  initial begin
    logic [7:0] lf;
    for (int b = 0; b < NB; b++) begin
      mState[b] = 2'd0;
      mBits[b]  = '0;
      mMem[b]   = '0;
      mOwner[b] = '0;
    end
    for (int i = 0; i < NP; i++) begin
      ackCnt[i] = 0;
      ackDat[i] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    check(reqReady == 1'b1, "R1 ready after reset", {127'd0, reqReady}, 128'd1);
    check(msgValid == '0, "R1 no messages after reset", {124'd0, msgValid}, 128'd0);
    check(rspValid == 1'b0, "R1 no reply after reset", {127'd0, rspValid}, 128'd0);

    doReq(0, 0, 5, 0);   // R1 R2: uncached read gives zero
    doReq(1, 0, 5, 0);   // R2: second sharer
    doReq(0, 2, 5, 0);   // R4: upgrade invalidates p1 only
    doReq(2, 0, 5, 1);   // R3 R9: fetch from p0, stray ack ignored
    doReq(3, 1, 5, 0);   // R4: invalidate p0 and p2, zero ack data ignored
    doReq(1, 3, 5, 1);   // R5 R9: code 3 as write, fetch-invalidate p3
    doReq(0, 1, 9, 0);   // R6: uncached write
    doReq(0, 1, 9, 0);   // R6: owner rewrites, no message
    doReq(0, 0, 15, 0);  // R2: last block
    doReq(2, 2, 15, 0);  // R4: invalidate p0
    doReq(3, 0, 9, 0);   // R3: read of dirty block
    doReq(1, 0, 5, 0);   // R2: read after earlier hand-off

    lf = 8'h5A;
    for (int k = 0; k < 60; k++) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      doReq(int'(lf[1:0]), int'(lf[3:2]), int'({2'b00, lf[5:4]}) + 8, (k % 3) == 0);
    end

    repeat (10) @(negedge clk);
    check(msgQ.size() == 0, "R7 all expected messages seen", msgQ.size(), 128'd0);
    check(rspQ.size() == 0, "R10 all expected replies seen", rspQ.size(), 128'd0);
    finishRun();
  end

endmodule